// File: doc/BRIEF.md
# Interrupt Mask Bank With Direction-Dependent Set/Clear Aliases

This block holds the interrupt enable mask of a bus-master engine and presents it on a simple single-cycle register port with 64-bit data. The engine supplies sixteen level-sensitive condition lines. The bank combines them with the mask and drives a single level interrupt line. Three register offsets are decoded. The mask offset is an ordinary read/write register. The two condition offsets do different things for reads and for writes. A read returns a condition view, either raw or masked. A write updates the mask atomically, as an OR-set or an AND-clear. Software can therefore enable or disable chosen interrupts without a read-modify-write sequence.

The interrupt field sits at word bits 16 to 31 in MSB-first numbering, which is bits 47 down to 32 counting from the LSB. Every view uses the same layout. Word bit 47 (MSB-first bit 16) is the invalid-command condition and word bit 46 (MSB-first bit 17) is the local-bus parity condition. Condition input `cond_i[15]` feeds word bit 47 and `cond_i[0]` feeds word bit 32.

Internally, a decoder turns each request into one named operation. The mask register process moves from its current value to a next value through one of four transitions:
- HOLD: no mask write, or any read.
- LOAD: a write to the mask offset.
- SET: a write to the OR alias.
- CLEAR: a write to the AND alias.

A read path registers the selected view. An output register holds the interrupt line.

Top module: `imask_bank`

## Requirements
- R1: After reset the mask is all zeros, `irq_o` is 0 and `rsp_valid` is 0. A read of offset 0x8 then returns 0.
- R2: A write to offset 0x8 loads word bits 47..32 of the data into the mask. A read of 0x8 returns the mask in bits 47..32. All bits outside 47..32 read as zero on every read.
- R3: A read of offset 0x9 returns the raw condition lines in bits 47..32, with `cond_i[15]` at bit 47 (invalid command) and `cond_i[14]` at bit 46 (local-bus parity).
- R4: A write to offset 0x9 ORs data bits 47..32 into the mask.
- R5: A read of offset 0xA returns the condition lines ANDed with the mask, in bits 47..32.
- R6: A write to offset 0xA ANDs data bits 47..32 into the mask. Writing the complement of the whole field clears every mask bit.
- R7: Writes to 0x9 or 0xA never change what the condition views return. A raw read after such a write still equals the condition lines.
- R8: `irq_o` is the OR of all masked condition bits, registered. A mask or condition change at clock edge N shows on `irq_o` after edge N+1.
- R9: Each read produces exactly one `rsp_valid` pulse, one cycle after the request, with the data reflecting state before that edge. Writes produce no response.
- R10: A read of any other offset returns zero. A write to any other offset leaves the mask unchanged.
- R11: A raw condition bit follows its input level and reads as 0 once the source drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register offset |
| req_wdata | input | 64 | Write data |
| cond_i | input | 16 | Level condition lines from the engine |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| irq_o | output | 1 | Level interrupt |

## Verification
A corrupted mask bit shows up in three places. It appears on the next read of offset 0x8 or of the masked view. It also changes `irq_o` two edges after the faulty update, once a matching condition line is driven high. A mis-decoded alias shows in the next mask read, because it loads or clears bits instead of setting them. It also shows in a raw read that returns mask data instead of the condition lines. The stimulus keeps conditions and mask in overlapping but unequal patterns, so that an OR or AND that is swapped or dropped changes an observed value.

// File: rtl/imask_pkg.sv
package imask_pkg;

    // Operation decoded from one register port access
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_WR_MASK,
        OP_SET_MASK,
        OP_CLR_MASK,
        OP_RD_MASK,
        OP_RD_RAW,
        OP_RD_MASKED,
        OP_RD_NONE
    } imask_op_e;

endpackage

// File: rtl/imask_decode.sv
module imask_decode
    import imask_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter logic [3:0]  OFS_MASK   = 4'h8,
    parameter logic [3:0]  OFS_RAW    = 4'h9,
    parameter logic [3:0]  OFS_MASKED = 4'hA
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output imask_op_e         op
);

    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);
    localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(OFS_MASKED);

    always_comb begin
        op = OP_IDLE;
        if (req_valid) begin
            if (req_addr == A_MASK) begin
                op = req_write ? OP_WR_MASK : OP_RD_MASK;
            end else if (req_addr == A_RAW) begin
                op = req_write ? OP_SET_MASK : OP_RD_RAW;
            end else if (req_addr == A_MASKED) begin
                op = req_write ? OP_CLR_MASK : OP_RD_MASKED;
            end else begin
                op = req_write ? OP_IDLE : OP_RD_NONE;
            end
        end
    end

endmodule

// File: rtl/imask_mask_reg.sv
module imask_mask_reg
    import imask_pkg::*;
#(
    parameter int FIELD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  imask_op_e          op,
    input  logic [FIELD_W-1:0] wfield,
    output logic [FIELD_W-1:0] mask_q
);

    logic [FIELD_W-1:0] mask_d;

    // next-state: HOLD, LOAD, SET, CLEAR
    always_comb begin
        unique case (op)
            OP_WR_MASK:  mask_d = wfield;
            OP_SET_MASK: mask_d = mask_q | wfield;
            OP_CLR_MASK: mask_d = mask_q & wfield;
            default:     mask_d = mask_q;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

endmodule

// File: rtl/imask_read_path.sv
module imask_read_path
    import imask_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int FIELD_W = 16,
    parameter int BOT_IDX = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  imask_op_e          op,
    input  logic [FIELD_W-1:0] mask_q,
    input  logic [FIELD_W-1:0] cond_i,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata
);

    logic [FIELD_W-1:0] view;
    logic               is_read;
    logic [DATA_W-1:0]  word_d;

    always_comb begin
        is_read = 1'b1;
        unique case (op)
            OP_RD_MASK:   view = mask_q;
            OP_RD_RAW:    view = cond_i;
            OP_RD_MASKED: view = cond_i & mask_q;
            OP_RD_NONE:   view = '0;
            default: begin
                view    = '0;
                is_read = 1'b0;
            end
        endcase
        word_d = '0;
        word_d[BOT_IDX +: FIELD_W] = view;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= is_read;
            rsp_rdata <= is_read ? word_d : '0;
        end
    end

endmodule

// File: rtl/imask_bank.sv
module imask_bank
    import imask_pkg::*;
#(
    parameter int         DATA_W      = 64,
    parameter int         ADDR_W      = 4,
    parameter int         FIELD_FIRST = 16,  // MSB-first index of field start
    parameter int         FIELD_LAST  = 31,  // MSB-first index of field end
    parameter logic [3:0] OFS_MASK    = 4'h8,
    parameter logic [3:0] OFS_RAW     = 4'h9,
    parameter logic [3:0] OFS_MASKED  = 4'hA
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    input  logic                                req_write,
    input  logic [ADDR_W-1:0]                   req_addr,
    input  logic [DATA_W-1:0]                   req_wdata,
    input  logic [FIELD_LAST-FIELD_FIRST:0]     cond_i,
    output logic                                rsp_valid,
    output logic [DATA_W-1:0]                   rsp_rdata,
    output logic                                irq_o
);

    localparam int FIELD_W = FIELD_LAST - FIELD_FIRST + 1;
    localparam int BOT_IDX = DATA_W - 1 - FIELD_LAST;

    imask_op_e          op;
    logic [FIELD_W-1:0] wfield;
    logic [FIELD_W-1:0] mask_q;
    logic               wdata_unused;

    assign wfield       = req_wdata[BOT_IDX +: FIELD_W];
    assign wdata_unused = ^req_wdata;

    imask_decode #(
        .ADDR_W(ADDR_W), .OFS_MASK(OFS_MASK),
        .OFS_RAW(OFS_RAW), .OFS_MASKED(OFS_MASKED)
    ) u_dec (
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .op(op)
    );

    imask_mask_reg #(.FIELD_W(FIELD_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .op(op), .wfield(wfield), .mask_q(mask_q)
    );

    imask_read_path #(
        .DATA_W(DATA_W), .FIELD_W(FIELD_W), .BOT_IDX(BOT_IDX)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .op(op), .mask_q(mask_q), .cond_i(cond_i),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // registered interrupt level
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(cond_i & mask_q);
    end

endmodule

// File: rtl/imask_bank_chk.sv
module imask_bank_chk #(
    parameter int         DATA_W     = 64,
    parameter int         ADDR_W     = 4,
    parameter int         FIELD_W    = 16,
    parameter int         BOT_IDX    = 32,
    parameter logic [3:0] OFS_MASK   = 4'h8,
    parameter logic [3:0] OFS_RAW    = 4'h9,
    parameter logic [3:0] OFS_MASKED = 4'hA
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [DATA_W-1:0]  req_wdata,
    input logic [FIELD_W-1:0] cond_i,
    input logic               rsp_valid,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic               irq_o,
    input logic [FIELD_W-1:0] mask_q
);

    localparam logic [DATA_W-1:0] FMASK = {FIELD_W{1'b1}} << BOT_IDX;

    logic [FIELD_W-1:0] wf;
    logic wr_or, wr_and, wr_any, rd_raw;
    assign wf     = req_wdata[BOT_IDX +: FIELD_W];
    assign wr_or  = req_valid && req_write && req_addr == ADDR_W'(OFS_RAW);
    assign wr_and = req_valid && req_write && req_addr == ADDR_W'(OFS_MASKED);
    assign wr_any = wr_or || wr_and ||
                    (req_valid && req_write && req_addr == ADDR_W'(OFS_MASK));
    assign rd_raw = req_valid && !req_write && req_addr == ADDR_W'(OFS_RAW);

    AST_RDATA_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_rdata & ~FMASK) == '0);                                        // R2
    AST_RAW_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_raw |=> rsp_rdata[BOT_IDX +: FIELD_W] == $past(cond_i));         // R3
    AST_OR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_or |=> (mask_q & $past(wf)) == $past(wf));                       // R4
    AST_AND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_and |=> (mask_q & ~$past(wf)) == '0);                            // R6
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_o == $past(|(cond_i & mask_q)));                       // R8
    AST_RSP_PER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rsp_valid == $past(req_valid && !req_write));              // R9
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_any |=> $stable(mask_q));                                       // R10

endmodule

bind imask_bank imask_bank_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .BOT_IDX(BOT_IDX),
    .OFS_MASK(OFS_MASK), .OFS_RAW(OFS_RAW), .OFS_MASKED(OFS_MASKED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .cond_i(cond_i),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_o(irq_o),
    .mask_q(mask_q)
);

// File: tb/tb_imask_bank.sv
module tb_imask_bank;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [3:0]  req_addr;
    logic [63:0] req_wdata;
    logic [15:0] cond_i;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        irq_o;

    always #5 clk = ~clk;

    imask_bank dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cond_i(cond_i),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] mask_m;

    function automatic logic [63:0] fw(input logic [15:0] f);
        return {16'h0, f, 32'h0};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        case (a)
            4'h8: mask_m = d[47:32];
            4'h9: mask_m = mask_m | d[47:32];
            4'hA: mask_m = mask_m & d[47:32];
            default: ;
        endcase
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, input string tag);
        logic [63:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        case (a)
            4'h8: e = fw(mask_m);
            4'h9: e = fw(cond_i);
            4'hA: e = fw(cond_i & mask_m);
            default: e = '0;
        endcase
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_irq(input string tag);
        @(negedge clk); @(negedge clk);
        check(tag, {63'h0, irq_o}, {63'h0, |(cond_i & mask_m)});
    endtask

    // monitor: pops expected read data as responses arrive
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected response", 64'h1, 64'h0);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; cond_i = '0; mask_m = '0;
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", {63'h0, rsp_valid}, 64'h0);
        check("R1 irq in reset", {63'h0, irq_o}, 64'h0);
        rst_n = 1'b1;
        do_read(4'h8, "R1 mask after reset");

        // invalid command + parity conditions active, mask still zero
        cond_i = 16'hC000;
        do_read(4'h9, "R3 raw view");
        do_read(4'hA, "R5 masked view with zero mask");
        check_irq("R8 irq with zero mask");

        do_write(4'h8, 64'hFFFF_FFFF_FFFF_FFFF);
        do_read(4'h8, "R2 mask load, outside bits zero");
        do_write(4'hA, ~fw(16'hFFFF));
        do_read(4'h8, "R6 complement clears all");

        // R8 latency: enable invalid-command bit at edge N
        do_write(4'h9, fw(16'h8000));
        check("R8 irq not yet", {63'h0, irq_o}, 64'h0);
        @(negedge clk);
        check("R8 irq one edge later", {63'h0, irq_o}, 64'h1);

        do_write(4'h9, fw(16'h0101));
        do_read(4'h8, "R4 OR alias sets");
        do_read(4'h9, "R7 raw unchanged after alias write");
        do_read(4'hA, "R5 masked view");
        do_write(4'hA, fw(16'hFF00));
        do_read(4'h8, "R6 AND alias clears");
        do_read(4'h9, "R7 raw unchanged after AND write");

        cond_i = 16'h0000;
        do_read(4'h9, "R11 raw drops with source");
        check_irq("R8 irq drops");

        do_write(4'h3, 64'hFFFF_FFFF_FFFF_FFFF);
        do_write(4'hB, 64'h0);
        do_read(4'h3, "R10 unmapped read zero");
        do_read(4'h8, "R10 mask unchanged by unmapped writes");

        cond_i = 16'h0100;
        check_irq("R8 irq from low field bit");
        cond_i = 16'h4000;
        do_read(4'hA, "R5 parity bit masked off");
        check_irq("R8 irq off for masked bit");

        repeat (3) @(negedge clk);
        check("R9 all reads answered", 64'(exp_q.size()), 64'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule